// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Output

An 8-bit up/down counter that advances once per clock and compares itself against a programmable compare value. A 2-bit counting-mode field picks one of four sequences: a free-running up-count, a count that restarts from zero after matching the compare value, a single-slope PWM and a dual-slope (phase-correct) PWM. A 2-bit output-action field decides what a match does to a single waveform output bit. In the PWM modes the output is also set or cleared at the turning points of the count.

Four byte-wide registers make up the software interface: control, counter, compare value and flags. Both flags are sticky and are cleared by writing a one to them. Writing the control register with its top bit set forces the output action at once, with no other side effect. The block also reports whether its waveform should take over the pin, and it drives a pin output enable that follows a direction input.

Top module: `cmp_timer`

## Requirements
- R1: After a synchronous reset the counter, compare value, control fields, both flags, the waveform output, the pin enable and the read data are all zero.
- R2: Control bits [1:0] hold the mode (00 free-run, 01 dual-slope PWM, 10 clear-on-match, 11 single-slope PWM). In free-run mode the counter adds one each clock and wraps from 0xFF to 0x00. The overflow flag (flags bit 1) is set on the clock that the counter leaves 0xFF in free-run, clear-on-match and single-slope modes.
- R3: In clear-on-match mode the counter holds a value equal to the active compare value for one clock and then goes to zero.
- R4: The compare flag (flags bit 0) is set on every clock where the counter equals the active compare value and the match is not blocked. Writing a one to a flag bit at address 3 clears it, and a new set in the same clock wins.
- R5: A write to the compare register (address 2) becomes active at once in free-run and clear-on-match modes, at the clock where the counter leaves 0xFF in single-slope PWM, and at the top turning point in dual-slope PWM. Reading address 2 returns the last value written.
- R6: In free-run and clear-on-match modes, the action field (control bits [3:2]) selects what a match does: 00 leaves the output alone, 01 inverts it, 10 drives it low and 11 drives it high.
- R7: In single-slope PWM, action 10 drives the output low on a match and high when the counter leaves 0xFF. Action 11 does the reverse. The wrap action wins when both occur together, and actions 00 and 01 leave the output alone.
- R8: In dual-slope PWM the counter runs 0x00 up to 0xFF and back down to 0x00, and 0xFE follows 0xFF. The overflow flag is set when the counter leaves 0x00 while falling. With action 10 a match drives the output low on the rising slope and high on the falling slope, and action 11 does the reverse. A count of 0x00 counts as rising and a count of 0xFF counts as falling.
- R9: A control write with bit 7 set applies the written action to the output on that clock, but only when the written mode is free-run or clear-on-match. It sets no flag and does not restart the counter. Bit 7 always reads as zero.
- R10: Writing the counter (address 1) suppresses compare matches on the clock of the write and on the following clock. The write also suppresses the overflow and wrap events of that clock.
- R11: `wave_ovr` is high whenever the action field is nonzero. `pin_oe` is high one clock after both a nonzero action field and `dir_en` are present.
- R12: `reg_rdata` shows, one clock later, the register selected by `reg_addr`. Control reads back as {0000, action, mode}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 counter, 2 compare, 3 flags |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| dir_en | input | 1 | Direction enable of the pin driver |
| wave_out | output | 1 | Waveform output bit |
| wave_ovr | output | 1 | The waveform owns the pin (action field nonzero) |
| pin_oe | output | 1 | Registered output enable of the pin driver |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Every result is due one clock after its cause. A write lands on the edge that samples it. Matches, flags and output actions take effect on the edge where the counter holds the matching value, and the read data and `pin_oe` follow their inputs by one edge. The bench advances a per-clock reference model on the same rising edge as the design and compares every output on the falling edge, so each comparison sees the state after exactly one edge. Directed sequences add hand-counted waits for compare-register buffering, match blocking after counter writes and the forced action.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_PHASE  = 2'b01,
    MD_CTC    = 2'b10,
    MD_FAST   = 2'b11
  } tmode_e;

  typedef enum logic [1:0] {
    WO_OFF    = 2'b00,
    WO_TOGGLE = 2'b01,
    WO_CLEAR  = 2'b10,
    WO_SET    = 2'b11
  } wact_e;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_CMP   = 2'd2;
  localparam logic [1:0] A_FLAG  = 2'd3;

  function automatic logic is_pwm(input tmode_e m);
    return (m == MD_PHASE) || (m == MD_FAST);
  endfunction

  function automatic logic act_apply(input wact_e a, input logic cur);
    case (a)
      WO_TOGGLE: return ~cur;
      WO_CLEAR:  return 1'b0;
      WO_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   addr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt_in,
  input  logic         match_ev,
  input  logic         ovf_ev,
  output tmode_e       mode_o,
  output wact_e        act_o,
  output logic [W-1:0] buf_o,
  output logic         cnt_wr_o,
  output logic         cmp_wr_o,
  output logic         force_o,
  output tmode_e       force_mode_o,
  output wact_e        force_act_o,
  output logic         cmp_flag_o,
  output logic         ovf_flag_o,
  output logic [W-1:0] rdata_o
);

  localparam int FORCE_BIT = W - 1;
  localparam int PAD_CTRL  = W - 4;
  localparam int PAD_FLAG  = W - 2;

  tmode_e       mode_q;
  wact_e        act_q;
  logic [W-1:0] buf_q;
  logic         cmp_f, ovf_f;
  logic [W-1:0] rdata_q;
  logic         ctrl_wr, flag_wr;
  logic [W-1:0] rd_mux;

  assign ctrl_wr      = wr && (addr == A_CTRL);
  assign flag_wr      = wr && (addr == A_FLAG);
  assign cnt_wr_o     = wr && (addr == A_COUNT);
  assign cmp_wr_o     = wr && (addr == A_CMP);
  assign force_o      = ctrl_wr && wdata[FORCE_BIT];
  assign force_mode_o = tmode_e'(wdata[1:0]);
  assign force_act_o  = wact_e'(wdata[3:2]);

  always_comb begin
    case (addr)
      A_CTRL:  rd_mux = {{PAD_CTRL{1'b0}}, act_q, mode_q};
      A_COUNT: rd_mux = cnt_in;
      A_CMP:   rd_mux = buf_q;
      default: rd_mux = {{PAD_FLAG{1'b0}}, ovf_f, cmp_f};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_NORMAL;
      act_q   <= WO_OFF;
      buf_q   <= '0;
      cmp_f   <= 1'b0;
      ovf_f   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= tmode_e'(wdata[1:0]);
        act_q  <= wact_e'(wdata[3:2]);
      end
      if (cmp_wr_o) buf_q <= wdata;
      cmp_f   <= match_ev | (cmp_f & ~(flag_wr & wdata[0]));
      ovf_f   <= ovf_ev   | (ovf_f & ~(flag_wr & wdata[1]));
      rdata_q <= rd_mux;
    end
  end

  assign mode_o     = mode_q;
  assign act_o      = act_q;
  assign buf_o      = buf_q;
  assign cmp_flag_o = cmp_f;
  assign ovf_flag_o = ovf_f;
  assign rdata_o    = rdata_q;

  AST_CMP_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    match_ev |=> cmp_f); // R4
  AST_FORCE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (force_o && !match_ev && !cmp_f) |=> !cmp_f); // R9
  AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == A_CTRL) |=> !rdata_q[FORCE_BIT]); // R9

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
  import cmp_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  tmode_e       mode,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cmp_buf,
  output logic [W-1:0] cnt_o,
  output logic         match_o,
  output logic         ovf_o,
  output logic         bottom_o,
  output logic         rising_o
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_MIN = '0;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q, act_q, nxt;
  logic         dn_q, blk_q, ndn, upd;
  logic         at_top, at_bot;

  assign at_top = (cnt_q == CNT_MAX);
  assign at_bot = (cnt_q == CNT_MIN);

  always_comb begin
    match_o  = (cnt_q == act_q) && !cnt_wr && !blk_q;
    nxt      = cnt_q + CNT_ONE;
    ndn      = 1'b0;
    ovf_o    = 1'b0;
    bottom_o = 1'b0;
    upd      = 1'b0;
    case (mode)
      MD_NORMAL: ovf_o = at_top;
      MD_CTC: begin
        ovf_o = at_top;
        if (match_o) nxt = CNT_MIN;
      end
      MD_FAST: begin
        ovf_o    = at_top;
        bottom_o = at_top;
        upd      = at_top;
      end
      default: begin
        if (!dn_q) begin
          upd = at_top;
          ndn = at_top;
          if (at_top) nxt = CNT_MAX - CNT_ONE;
        end else begin
          ovf_o = at_bot;
          ndn   = !at_bot;
          nxt   = at_bot ? CNT_ONE : (cnt_q - CNT_ONE);
        end
      end
    endcase
    if (cnt_wr) begin
      nxt      = wdata;
      ndn      = dn_q;
      ovf_o    = 1'b0;
      bottom_o = 1'b0;
      upd      = 1'b0;
    end
  end

  assign rising_o = at_bot || (!dn_q && !at_top);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= '0;
      dn_q  <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= nxt;
      dn_q  <= ndn;
      blk_q <= cnt_wr;
      if (!is_pwm(mode)) act_q <= cmp_wr ? wdata : cmp_buf;
      else if (upd)      act_q <= cmp_buf;
    end
  end

  assign cnt_o = cnt_q;

  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_NORMAL && !cnt_wr) |=> cnt_q == $past(cnt_q) + CNT_ONE); // R2
  AST_CTC_RESTART: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_CTC && match_o) |=> cnt_q == CNT_MIN); // R3
  AST_TOP_TURN: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_PHASE && !dn_q && at_top && !cnt_wr) |=> (dn_q && cnt_q == CNT_MAX - CNT_ONE)); // R8

endmodule

// File: rtl/cmp_timer_wave.sv
module cmp_timer_wave
  import cmp_timer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  tmode_e mode,
  input  wact_e  act,
  input  logic   match,
  input  logic   bottom,
  input  logic   rising,
  input  logic   force_p,
  input  tmode_e force_mode,
  input  wact_e  force_act,
  output logic   wave_o
);

  logic wave_q, nxt, pwm_on;

  assign pwm_on = (act == WO_CLEAR) || (act == WO_SET);

  always_comb begin
    nxt = wave_q;
    if (force_p && !is_pwm(force_mode)) begin
      nxt = act_apply(force_act, wave_q);
    end else begin
      case (mode)
        MD_FAST: begin
          if (pwm_on) begin
            if (bottom)     nxt = (act == WO_CLEAR);
            else if (match) nxt = (act == WO_SET);
          end
        end
        MD_PHASE: begin
          if (pwm_on && match) nxt = rising ? (act == WO_SET) : (act == WO_CLEAR);
        end
        default: begin
          if (match) nxt = act_apply(act, wave_q);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b0;
    else     wave_q <= nxt;
  end

  assign wave_o = wave_q;

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (!force_p && !is_pwm(mode) && act == WO_TOGGLE && match) |=> wave_q != $past(wave_q)); // R6
  AST_FAST_SET_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (!force_p && mode == MD_FAST && act == WO_CLEAR && bottom) |=> wave_q); // R7

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         dir_en,
  output logic         wave_out,
  output logic         wave_ovr,
  output logic         pin_oe,
  output logic         cmp_flag,
  output logic         ovf_flag
);

  tmode_e       mode, force_mode;
  wact_e        act, force_act;
  logic [W-1:0] cmp_buf, cnt;
  logic         cnt_wr, cmp_wr, force_p;
  logic         match, ovf, bottom, rising;
  logic         oe_q;

  cmp_timer_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .cnt_in(cnt), .match_ev(match), .ovf_ev(ovf),
    .mode_o(mode), .act_o(act), .buf_o(cmp_buf),
    .cnt_wr_o(cnt_wr), .cmp_wr_o(cmp_wr),
    .force_o(force_p), .force_mode_o(force_mode), .force_act_o(force_act),
    .cmp_flag_o(cmp_flag), .ovf_flag_o(ovf_flag), .rdata_o(reg_rdata)
  );

  cmp_timer_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .mode(mode), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr),
    .wdata(reg_wdata), .cmp_buf(cmp_buf), .cnt_o(cnt), .match_o(match),
    .ovf_o(ovf), .bottom_o(bottom), .rising_o(rising)
  );

  cmp_timer_wave u_wave (
    .clk(clk), .rst(rst), .mode(mode), .act(act), .match(match),
    .bottom(bottom), .rising(rising), .force_p(force_p),
    .force_mode(force_mode), .force_act(force_act), .wave_o(wave_out)
  );

  assign wave_ovr = (act != WO_OFF);

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= wave_ovr && dir_en;
  end

  assign pin_oe = oe_q;

endmodule

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       dir_en = 1'b0;
  logic       wave_out, wave_ovr, pin_oe, cmp_flag, ovf_flag;

  always #5 clk = ~clk;

  cmp_timer #(.W(8)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_en(dir_en),
    .wave_out(wave_out), .wave_ovr(wave_ovr), .pin_oe(pin_oe),
    .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
  );

  int errs = 0;
  int checks = 0;
  bit lock = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  logic [7:0] m_cnt, m_act, m_buf, m_rd;
  logic [1:0] m_mode, m_com;
  logic       m_dn, m_blk, m_cf, m_of, m_wave, m_oe;

  function automatic logic appl(input logic [1:0] c, input logic w);
    case (c)
      2'd1: return ~w;
      2'd2: return 1'b0;
      2'd3: return 1'b1;
      default: return w;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [7:0] n;
    logic nd, ov, bt, up, mt, rise, w, cw, nw, ow, fw;
    if (rst) begin
      m_cnt <= 0; m_act <= 0; m_buf <= 0; m_rd <= 0; m_mode <= 0; m_com <= 0;
      m_dn <= 0; m_blk <= 0; m_cf <= 0; m_of <= 0; m_wave <= 0; m_oe <= 0;
    end else begin
      cw = reg_wr && reg_addr == 2'd0;
      nw = reg_wr && reg_addr == 2'd1;
      ow = reg_wr && reg_addr == 2'd2;
      fw = reg_wr && reg_addr == 2'd3;
      mt = (m_cnt == m_act) && !nw && !m_blk;
      n = m_cnt + 8'd1; nd = 0; ov = 0; bt = 0; up = 0;
      case (m_mode)
        2'd0: ov = (m_cnt == 8'hFF);
        2'd2: begin ov = (m_cnt == 8'hFF); if (mt) n = 8'd0; end
        2'd3: begin ov = (m_cnt == 8'hFF); bt = ov; up = ov; end
        default: begin
          if (!m_dn) begin
            up = (m_cnt == 8'hFF); nd = up;
            if (up) n = 8'hFE;
          end else begin
            ov = (m_cnt == 8'h00); nd = (m_cnt != 8'h00);
            n = (m_cnt == 8'h00) ? 8'd1 : m_cnt - 8'd1;
          end
        end
      endcase
      if (nw) begin n = reg_wdata; nd = m_dn; ov = 0; bt = 0; up = 0; end
      rise = (m_cnt == 8'h00) || (!m_dn && m_cnt != 8'hFF);
      w = m_wave;
      if (cw && reg_wdata[7] && !reg_wdata[0]) w = appl(reg_wdata[3:2], m_wave);
      else begin
        case (m_mode)
          2'd3: if (m_com[1]) begin
                  if (bt) w = (m_com == 2'd2);
                  else if (mt) w = (m_com == 2'd3);
                end
          2'd1: if (m_com[1] && mt) w = rise ? (m_com == 2'd3) : (m_com == 2'd2);
          default: if (mt) w = appl(m_com, m_wave);
        endcase
      end
      case (reg_addr)
        2'd0: m_rd <= {4'd0, m_com, m_mode};
        2'd1: m_rd <= m_cnt;
        2'd2: m_rd <= m_buf;
        default: m_rd <= {6'd0, m_of, m_cf};
      endcase
      m_oe   <= (m_com != 0) && dir_en;
      m_cnt  <= n;
      m_dn   <= nd;
      m_blk  <= nw;
      m_wave <= w;
      if (!m_mode[0]) m_act <= ow ? reg_wdata : m_buf;
      else if (up)    m_act <= m_buf;
      if (cw) begin m_mode <= reg_wdata[1:0]; m_com <= reg_wdata[3:2]; end
      if (ow) m_buf <= reg_wdata;
      m_cf <= mt | (m_cf & !(fw & reg_wdata[0]));
      m_of <= ov | (m_of & !(fw & reg_wdata[1]));
    end
  end

  // lockstep comparison on the falling edge
  always @(negedge clk) begin
    if (lock && !rst && !done) begin
      chk(m_mode == 2'd3 ? "R7 wave" : (m_mode == 2'd1 ? "R8 wave" : "R6 wave"), wave_out, m_wave);
      chk("R4 cmp_flag", cmp_flag, m_cf);
      chk("R2 ovf_flag", ovf_flag, m_of);
      chk("R12 rdata", reg_rdata, m_rd);
      chk("R11 wave_ovr", wave_ovr, m_com != 0);
      chk("R11 pin_oe", pin_oe, m_oe);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, e);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state straight out of reset
    chk("R1 wave", wave_out, 0);
    chk("R1 cmp_flag", cmp_flag, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 rdata", reg_rdata, 0);
    lock = 1'b1;
    rd_chk(2'd0, 8'h00, "R1 ctrl");
    rd_chk(2'd2, 8'h00, "R1 compare");

    // R9: forced toggle, no flag, bit 7 reads zero
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h10);
    wr(2'd3, 8'h03);
    wr(2'd0, 8'h84);
    chk("R9 forced wave", wave_out, 1);
    chk("R9 no flag", cmp_flag, 0);
    rd_chk(2'd0, 8'h04, "R9 force reads zero");

    // R10: counter written to the compare value, match blocked
    wr(2'd3, 8'h03);
    wr(2'd1, 8'h80);
    @(negedge clk);
    chk("R10 blocked flag", cmp_flag, 0);
    chk("R10 blocked wave", wave_out, 1);

    // R3: clear-on-match keeps the count at or below the compare value
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h00);
    repeat (10) @(negedge clk);
    reg_addr = 2'd1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R3 ctc range", reg_rdata <= 8'h03, 1);
    end

    // R5: single-slope compare value buffered until the wrap
    wr(2'd2, 8'h40);
    wr(2'd0, 8'h0B);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'hF0);
    repeat (8'h50) @(negedge clk);
    chk("R5 old compare still active", wave_out, 0);
    rd_chk(2'd2, 8'hF0, "R5 readback");
    repeat (254) @(negedge clk);
    chk("R5 new compare after wrap", wave_out, 1);

    // constrained random segments
    for (int s = 0; s < 40; s++) begin
      logic [1:0] md, cm;
      int len;
      md = 2'($urandom);
      cm = 2'($urandom);
      wr(2'd2, 8'($urandom));
      wr(2'd0, {4'd0, cm, md});
      if ($urandom % 2) wr(2'd1, 8'($urandom));
      if (s % 3 == 0) wr(2'd2, (s % 2) ? 8'hFF : 8'h00);
      len = 300 + int'($urandom % 400);
      for (int c = 0; c < len; c++) begin
        int r;
        @(negedge clk);
        r = int'($urandom % 200);
        reg_wr = 1'b0;
        reg_addr = 2'($urandom);
        if (r < 4) begin
          reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'($urandom % 4);
        end else if (r < 6) begin
          reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {1'b1, 3'd0, cm, 2'($urandom)};
        end else if (r < 8) begin
          reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'($urandom);
        end else if (r < 10) begin
          reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'($urandom);
        end else if (r < 12) begin
          dir_en = ~dir_en;
        end
      end
      @(negedge clk);
      reg_wr = 1'b0;
    end

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule